// File: doc/BRIEF.md
# Conditional Select and Conditional Compare Unit

This block is the condition-driven arm of an integer execution pipeline. From a 4-bit condition code and the current sign, zero, carry and overflow flags it decides whether a condition holds. It then either picks between two register operands, where the second operand may first be incremented, inverted or negated, or it carries out a conditional compare. A conditional compare produces new flags from the operands when the condition holds. When the condition fails, it loads a constant flag value supplied with the operation instead.

The unit is purely combinational. Register reads and writebacks stay with the surrounding pipeline, which feeds the operands, the flag state and the operation fields in and takes the result, the next flags and a flag-write strobe out. A width select makes every operation act on either the full 64-bit operands or their low 32 bits. The two condition-set forms are built on the select paths with zero operands and the inverted condition, so they need no datapath of their own.

Top module: `csc_unit`

## Requirements
- R1: The condition code selects a test of the flag input, which is packed {N,Z,C,V} in bits 3..0. The codes are: 0 Z set; 1 Z clear; 2 C set; 3 C clear; 4 N set; 5 N clear; 6 V set; 7 V clear; 8 C set and Z clear; 9 not (C set and Z clear); 10 N equals V; 11 N differs from V; 12 Z clear and N equals V; 13 not (Z clear and N equals V); 14 and 15 always true.
- R2: With op 0 (plain select), the result is operand A when the condition holds and operand B otherwise.
- R3: With op 1 (select-increment), the result is A when the condition holds and B plus one otherwise, wrapping within the active width.
- R4: With op 2 (select-invert), the result is A when the condition holds and the bitwise complement of B otherwise.
- R5: With op 3 (select-negate), the result is A when the condition holds and the two's complement negation of B otherwise.
- R6: When the width select is 0, every operation uses only the low 32 bits of the operands, and result bits 63..32 are zero. When it is 1, all 64 bits are used.
- R7: Op 4 (condition-set) gives 1 when the condition holds and 0 otherwise. Op 5 (condition-set-mask) gives all ones of the active width when the condition holds and 0 otherwise. Neither depends on A or B.
- R8: With op 6 (conditional compare) and the condition holding, the output flags are those of A minus B at the active width: N is the result sign, Z is set when the result is zero, C is 1 when there is no borrow, and V is set on signed overflow.
- R9: With op 7 (negated conditional compare) and the condition holding, the output flags are those of A plus B at the active width: C is the unsigned carry out and V is set on signed overflow.
- R10: With op 6 or 7 and the condition failing, the output flags equal the 4-bit default flag input ({N,Z,C,V}), whatever the operands are.
- R11: The flag-write strobe is 1 only for ops 6 and 7. For ops 0 to 5 the output flags equal the input flags. For ops 6 and 7 the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 64 | First register operand (A) |
| opb_i | input | 64 | Second register operand (B) |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| op_i | input | 3 | Operation selector, codes 0 to 7 |
| wide_i | input | 1 | 1 = 64-bit, 0 = 32-bit |
| dflt_flags_i | input | 4 | Flags loaded by a compare whose condition fails |
| result_o | output | 64 | Selected or transformed value |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| flags_we_o | output | 1 | Strobe asking the pipeline to store flags_o |

## Verification
All sixteen condition codes are applied against all sixteen flag combinations through the plain select. This separates a wrong flag test from a wrong pairing of a code with its inverse. Each transforming select is driven with its condition failing on operands at the wrap points: all ones, zero, and the most negative value at each width. Operands whose upper half is non-zero are included, which exposes a result that is not confined to 32 bits. The compare tests use operands chosen to give a zero result, a borrow, a signed overflow in each direction, and the classic sum of two maximum positives. They are run with the condition both holding and failing, so that computed flags can be told apart from loaded default flags.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int unsigned XLEN = 64;
    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned FLAG_W = 4;
    localparam int unsigned CODE_W = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        OP_SEL   = 3'd0,
        OP_SINC  = 3'd1,
        OP_SINV  = 3'd2,
        OP_SNEG  = 3'd3,
        OP_SET   = 3'd4,
        OP_SETM  = 3'd5,
        OP_CMP   = 3'd6,
        OP_CMN   = 3'd7
    } csc_op_e;

    typedef enum logic [1:0] {
        ALT_PASS = 2'd0,
        ALT_INC  = 2'd1,
        ALT_INV  = 2'd2,
        ALT_NEG  = 2'd3
    } alt_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic word_t lane_mask(input logic wide);
        return wide ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
    endfunction

    function automatic logic lane_msb(input word_t w, input logic wide);
        return wide ? w[XLEN-1] : w[HALF-1];
    endfunction

    function automatic logic is_compare(input csc_op_e op);
        return (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/csc_cond_eval.sv
module csc_cond_eval
    import csc_pkg::*;
(
    input  nzcv_t             flags_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              hold_o
);
    logic base;

    // Even codes carry the base test, odd codes its inverse; top pair always true.
    always_comb begin
        unique case (code_i[CODE_W-1:1])
            3'd0:    base = flags_i.z;
            3'd1:    base = flags_i.c;
            3'd2:    base = flags_i.n;
            3'd3:    base = flags_i.v;
            3'd4:    base = flags_i.c & ~flags_i.z;
            3'd5:    base = (flags_i.n == flags_i.v);
            3'd6:    base = ~flags_i.z & (flags_i.n == flags_i.v);
            default: base = 1'b1;
        endcase
        if (code_i[CODE_W-1:1] == 3'd7)
            hold_o = 1'b1;
        else
            hold_o = code_i[0] ? ~base : base;
    end

endmodule

// File: rtl/csc_select.sv
module csc_select
    import csc_pkg::*;
(
    input  csc_op_e op_i,
    input  logic    hold_i,
    input  logic    wide_i,
    input  word_t   a_i,
    input  word_t   b_i,
    output word_t   res_o
);
    word_t     mask;
    word_t     src_a;
    word_t     src_b;
    word_t     alt;
    logic      take_a;
    alt_kind_e kind;

    always_comb begin
        mask   = lane_mask(wide_i);
        src_a  = a_i;
        src_b  = b_i;
        take_a = hold_i;
        kind   = ALT_PASS;
        unique case (op_i)
            OP_SEL:  kind = ALT_PASS;
            OP_SINC: kind = ALT_INC;
            OP_SINV: kind = ALT_INV;
            OP_SNEG: kind = ALT_NEG;
            OP_SET, OP_SETM: begin
                // condition-set reuses the increment/invert path on zero
                src_a  = '0;
                src_b  = '0;
                take_a = ~hold_i;
                kind   = (op_i == OP_SET) ? ALT_INC : ALT_INV;
            end
            default: kind = ALT_PASS;
        endcase

        unique case (kind)
            ALT_INC: alt = src_b + word_t'(1);
            ALT_INV: alt = ~src_b;
            ALT_NEG: alt = word_t'(0) - src_b;
            default: alt = src_b;
        endcase

        if (is_compare(op_i))
            res_o = '0;
        else
            res_o = (take_a ? src_a : alt) & mask;

        if (!$isunknown({op_i, wide_i, hold_i})) begin
            p_upper_clear_r6: assert (wide_i || res_o[XLEN-1:HALF] == '0)
                else $error("upper half not cleared in narrow mode");
            p_set_bool_r7: assert (op_i != OP_SET || res_o == word_t'(hold_i))
                else $error("condition-set result not boolean");
            p_setm_span_r7: assert (op_i != OP_SETM || res_o == (hold_i ? mask : '0))
                else $error("condition-set-mask result wrong");
        end
    end

endmodule

// File: rtl/csc_flag_unit.sv
module csc_flag_unit
    import csc_pkg::*;
(
    input  csc_op_e op_i,
    input  logic    hold_i,
    input  logic    wide_i,
    input  word_t   a_i,
    input  word_t   b_i,
    input  nzcv_t   flags_i,
    input  nzcv_t   dflt_i,
    output nzcv_t   flags_o,
    output logic    we_o
);
    word_t        mask;
    word_t        am;
    word_t        bm;
    logic [XLEN:0] sum;
    word_t        res;
    logic         cin;
    logic         sgn_a;
    logic         sgn_b;
    logic         sgn_r;
    nzcv_t        calc;

    always_comb begin
        mask  = lane_mask(wide_i);
        cin   = (op_i == OP_CMP);
        am    = a_i & mask;
        bm    = (cin ? ~b_i : b_i) & mask;
        sum   = {1'b0, am} + {1'b0, bm} + {{XLEN{1'b0}}, cin};
        res   = sum[XLEN-1:0] & mask;
        sgn_a = lane_msb(am, wide_i);
        sgn_b = lane_msb(bm, wide_i);
        sgn_r = lane_msb(res, wide_i);

        calc.n = sgn_r;
        calc.z = (res == '0);
        calc.c = wide_i ? sum[XLEN] : sum[HALF];
        calc.v = (sgn_a == sgn_b) && (sgn_r != sgn_a);

        we_o = is_compare(op_i);
        if (!we_o)
            flags_o = flags_i;
        else if (hold_i)
            flags_o = calc;
        else
            flags_o = dflt_i;

        if (!$isunknown({op_i, hold_i, flags_i, dflt_i})) begin
            p_keep_flags_r11: assert (we_o || flags_o == flags_i)
                else $error("select op altered flags");
            p_default_load_r10: assert (!(we_o && !hold_i) || flags_o == dflt_i)
                else $error("default flags not loaded");
            p_zero_not_neg_r8: assert (!(we_o && hold_i && flags_o.z) || !flags_o.n)
                else $error("zero result flagged negative");
        end
    end

endmodule

// File: rtl/csc_unit.sv
module csc_unit
    import csc_pkg::*;
(
    input  logic [63:0] opa_i,
    input  logic [63:0] opb_i,
    input  logic [3:0]  cond_i,
    input  logic [3:0]  flags_i,
    input  logic [2:0]  op_i,
    input  logic        wide_i,
    input  logic [3:0]  dflt_flags_i,
    output logic [63:0] result_o,
    output logic [3:0]  flags_o,
    output logic        flags_we_o
);
    csc_op_e op;
    nzcv_t   cur_flags;
    nzcv_t   dflt_flags;
    nzcv_t   nxt_flags;
    logic    hold;

    assign op         = csc_op_e'(op_i);
    assign cur_flags  = nzcv_t'(flags_i);
    assign dflt_flags = nzcv_t'(dflt_flags_i);

    csc_cond_eval u_cond (
        .flags_i (cur_flags),
        .code_i  (cond_i),
        .hold_o  (hold)
    );

    csc_select u_sel (
        .op_i   (op),
        .hold_i (hold),
        .wide_i (wide_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .res_o  (result_o)
    );

    csc_flag_unit u_flags (
        .op_i    (op),
        .hold_i  (hold),
        .wide_i  (wide_i),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .flags_i (cur_flags),
        .dflt_i  (dflt_flags),
        .flags_o (nxt_flags),
        .we_o    (flags_we_o)
    );

    assign flags_o = nxt_flags;

endmodule

// File: tb/tb_csc_unit.sv
`timescale 1ns/1ps
module tb_csc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa, opb, result;
    logic [3:0]  cond, flags, dflt, flags_out;
    logic [2:0]  op;
    logic        wide, we;
    int          n_checks = 0;
    int          n_fail = 0;

    localparam logic [63:0] LO = 64'h0000_0000_FFFF_FFFF;

    always #5 clk = ~clk;

    csc_unit dut (
        .opa_i(opa), .opb_i(opb), .cond_i(cond), .flags_i(flags), .op_i(op),
        .wide_i(wide), .dflt_flags_i(dflt), .result_o(result),
        .flags_o(flags_out), .flags_we_o(we)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [3:0] c, input logic [3:0] f,
                         input logic w, input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] d);
        @(negedge clk);
        op = o; cond = c; flags = f; wide = w; opa = a; opb = b; dflt = d;
        #2;
    endtask

    function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !(cy && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    // Reference flags of a-b (sub=1) or a+b (sub=0) from arithmetic definitions
    function automatic logic [3:0] ref_flags(input logic sub, input logic w,
                                             input logic [63:0] a, input logic [63:0] b);
        logic signed [65:0] sa, sb, sr;
        logic [64:0] ua, ub;
        logic [63:0] r;
        logic n, z, cy, v;
        if (w) begin
            ua = {1'b0, a}; ub = {1'b0, b};
            sa = {{2{a[63]}}, a}; sb = {{2{b[63]}}, b};
        end else begin
            ua = {33'd0, a[31:0]}; ub = {33'd0, b[31:0]};
            sa = {{34{a[31]}}, a[31:0]}; sb = {{34{b[31]}}, b[31:0]};
        end
        if (sub) begin
            r  = ua[63:0] - ub[63:0];
            cy = (ua >= ub);
            sr = sa - sb;
        end else begin
            r  = ua[63:0] + ub[63:0];
            cy = w ? ((ua + ub) > 65'h0_FFFF_FFFF_FFFF_FFFF) : ((ua + ub) > 65'h0_FFFF_FFFF);
            sr = sa + sb;
        end
        if (!w) r = r & LO;
        n = w ? r[63] : r[31];
        z = (r == 64'd0);
        v = w ? (sr > 66'sh0_7FFF_FFFF_FFFF_FFFF || sr < -66'sh0_8000_0000_0000_0000)
              : (sr > 66'sh7FFF_FFFF || sr < -66'sh8000_0000);
        return {n, z, cy, v};
    endfunction

    task automatic t_idle;
        drive(3'd0, 4'd0, 4'b0000, 1'b1, 64'd0, 64'd0, 4'b0000);
        chk("R2 idle result", result, 64'd0);
        chk("R11 idle strobe", {63'd0, we}, 64'd0);
        chk("R11 idle flags", {60'd0, flags_out}, 64'd0);
    endtask

    task automatic t_cond_table;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(3'd0, c[3:0], f[3:0], 1'b1, 64'hAAAA_0000_0000_0001,
                      64'h5555_0000_0000_0002, 4'b0000);
                chk("R1 R2 condition select", result,
                    ref_cond(c[3:0], f[3:0]) ? 64'hAAAA_0000_0000_0001 : 64'h5555_0000_0000_0002);
                chk("R11 select keeps flags", {60'd0, flags_out}, {60'd0, f[3:0]});
            end
        end
    endtask

    task automatic t_transforms;
        // cond 1 with Z set fails; cond 0 with Z set holds
        drive(3'd1, 4'd1, 4'b0100, 1'b1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000);
        chk("R3 inc wrap 64", result, 64'd0);
        drive(3'd1, 4'd0, 4'b0100, 1'b1, 64'h1234, 64'h7, 4'b0000);
        chk("R3 inc holds gives A", result, 64'h1234);
        drive(3'd1, 4'd1, 4'b0100, 1'b0, 64'h1, 64'h0000_0001_FFFF_FFFF, 4'b0000);
        chk("R3 R6 inc wrap 32", result, 64'd0);
        drive(3'd1, 4'd1, 4'b0100, 1'b0, 64'h1, 64'hDEAD_0001_0000_0005, 4'b0000);
        chk("R3 R6 inc ignores upper", result, 64'd6);
        drive(3'd2, 4'd1, 4'b0100, 1'b1, 64'h1, 64'h0F0F_0000_FFFF_0000, 4'b0000);
        chk("R4 invert 64", result, 64'hF0F0_FFFF_0000_FFFF);
        drive(3'd2, 4'd1, 4'b0100, 1'b0, 64'h1, 64'h0F0F_0000_FFFF_0000, 4'b0000);
        chk("R4 R6 invert 32", result, 64'h0000_0000_0000_FFFF);
        drive(3'd3, 4'd1, 4'b0100, 1'b1, 64'h1, 64'd5, 4'b0000);
        chk("R5 negate 64", result, 64'hFFFF_FFFF_FFFF_FFFB);
        drive(3'd3, 4'd1, 4'b0100, 1'b1, 64'h1, 64'd0, 4'b0000);
        chk("R5 negate zero", result, 64'd0);
        drive(3'd3, 4'd1, 4'b0100, 1'b0, 64'h1, 64'h0000_0000_8000_0000, 4'b0000);
        chk("R5 R6 negate min 32", result, 64'h0000_0000_8000_0000);
        drive(3'd3, 4'd1, 4'b0100, 1'b1, 64'h1, 64'h8000_0000_0000_0000, 4'b0000);
        chk("R5 negate min 64", result, 64'h8000_0000_0000_0000);
        drive(3'd0, 4'd0, 4'b0100, 1'b0, 64'hFFFF_FFFF_1234_5678, 64'h0, 4'b0000);
        chk("R2 R6 narrow select of A", result, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_cset;
        drive(3'd4, 4'd0, 4'b0100, 1'b1, 64'hFFFF, 64'hFFFF, 4'b0000);
        chk("R7 set holds", result, 64'd1);
        drive(3'd4, 4'd0, 4'b0000, 1'b1, 64'hFFFF, 64'hFFFF, 4'b0000);
        chk("R7 set fails", result, 64'd0);
        drive(3'd5, 4'd8, 4'b0010, 1'b1, 64'h5, 64'h5, 4'b0000);
        chk("R7 mask holds 64", result, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(3'd5, 4'd8, 4'b0010, 1'b0, 64'h5, 64'h5, 4'b0000);
        chk("R7 R6 mask holds 32", result, LO);
        drive(3'd5, 4'd8, 4'b0110, 1'b1, 64'h5, 64'h5, 4'b0000);
        chk("R7 mask fails", result, 64'd0);
        chk("R11 set no strobe", {63'd0, we}, 64'd0);
    endtask

    task automatic t_compare;
        logic [63:0] av [6];
        logic [63:0] bv [6];
        av[0] = 64'd5;                  bv[0] = 64'd5;
        av[1] = 64'd0;                  bv[1] = 64'd1;
        av[2] = 64'h8000_0000_0000_0000; bv[2] = 64'd1;
        av[3] = 64'h0000_0000_7FFF_FFFF; bv[3] = 64'h0000_0000_7FFF_FFFF;
        av[4] = 64'h7FFF_FFFF_FFFF_FFFF; bv[4] = 64'hFFFF_FFFF_FFFF_FFFF;
        av[5] = 64'h1234_0000_8000_0000; bv[5] = 64'h0000_0000_8000_0000;
        // hand-worked corner values
        drive(3'd6, 4'd14, 4'b0000, 1'b1, 64'd5, 64'd5, 4'b1111);
        chk("R8 equal operands", {60'd0, flags_out}, 64'b0110);
        chk("R11 compare strobe", {63'd0, we}, 64'd1);
        chk("R11 compare result zero", result, 64'd0);
        drive(3'd6, 4'd14, 4'b0000, 1'b1, 64'd0, 64'd1, 4'b1111);
        chk("R8 borrow", {60'd0, flags_out}, 64'b1000);
        drive(3'd6, 4'd14, 4'b0000, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 4'b1111);
        chk("R8 signed overflow", {60'd0, flags_out}, 64'b0011);
        drive(3'd7, 4'd14, 4'b0000, 1'b0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 4'b1111);
        chk("R9 max positive sum 32", {60'd0, flags_out}, 64'b1001);
        for (int i = 0; i < 6; i++) begin
            for (int w = 0; w < 2; w++) begin
                drive(3'd6, 4'd14, 4'b0000, w[0], av[i], bv[i], 4'b0000);
                chk("R8 compare flags", {60'd0, flags_out}, {60'd0, ref_flags(1'b1, w[0], av[i], bv[i])});
                drive(3'd7, 4'd14, 4'b0000, w[0], av[i], bv[i], 4'b0000);
                chk("R9 negated compare flags", {60'd0, flags_out}, {60'd0, ref_flags(1'b0, w[0], av[i], bv[i])});
                drive(3'd6, 4'd0, 4'b0000, w[0], av[i], bv[i], 4'(i + 9));
                chk("R10 default on fail", {60'd0, flags_out}, 64'(i + 9));
                drive(3'd7, 4'd6, 4'b1110, w[0], av[i], bv[i], 4'(i + 1));
                chk("R10 negated default on fail", {60'd0, flags_out}, 64'(i + 1));
                chk("R11 strobe on failed compare", {63'd0, we}, 64'd1);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        op = 3'd0; cond = 4'd0; flags = 4'd0; wide = 1'b1; opa = '0; opb = '0; dflt = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle;
        t_cond_table;
        t_transforms;
        t_cset;
        t_compare;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule